// File: doc/BRIEF.md
# Priority Interrupt Controller with Selectable External Triggers

This block gathers interrupt requests for a small 8-bit microcontroller core and presents the single most urgent one to the CPU as a 12-bit vector address. It handles one non-maskable line and four maskable sources: an external pin on port A, an external pin shared by ports B and C, a timer underflow flag and an analog-to-digital end-of-conversion flag. A write-only option byte, reached through a simple address/data write port, picks how the two external pins trigger and holds a global enable for the maskable sources.

Edge-triggered requests are held in pending latches that clear when the CPU acknowledges that vector. Level-triggered and peripheral-flag requests are not latched: they remain pending for as long as their input asserts. After an acknowledge, a nesting flag holds off all maskable requests until the CPU signals a return from interrupt. The non-maskable line can still interrupt during that time. Two wake outputs tell the low-power control logic whether a pending request may end WAIT or STOP.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A write with `opt_we_i` high and `opt_addr_i` = 0xC8 loads the option byte. The byte resets to 0x00, and writes to any other address leave it unchanged. Bit 6 is the port A level select, bit 5 the port B/C rising select and bit 4 the global enable. The other bits are discarded.
- R2: With bit 6 = 0, a falling edge on `pa_ni` latches a pending request that stays set after the pin returns high. Acknowledging that vector clears it.
- R3: With bit 6 = 1, port A is pending exactly while `pa_ni` is low, with no latching and no clock delay.
- R4: Bit 5 = 0 makes port B/C latch on a falling edge of `pbc_i`. Bit 5 = 1 makes it latch on a rising edge, and a falling edge is then ignored.
- R5: With bit 4 = 0, no maskable source raises `irq_o`, but a falling edge on `nmi_ni` still does.
- R6: When several requests are pending, the vector shown is the highest in this order: NMI, port A, port B/C, timer, ADC.
- R7: The vector addresses are NMI 0xFFC, port A 0xFF6, port B/C 0xFF4, timer 0xFF2 and ADC 0xFF0.
- R8: `ack_i` while `irq_o` is high sets a nesting state. In that state every maskable request is blocked until `reti_i`, while NMI is still presented.
- R9: With the global enable set, `wake_wait_o` is high whenever any request is pending, and `wake_stop_o` is high for any pending request other than ADC. With the enable clear, both are low, even for NMI.
- R10: The timer and ADC requests follow `tmr_flag_i` and `adc_flag_i`. An acknowledge does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opt_we_i | input | 1 | Option register write strobe |
| opt_addr_i | input | 8 | Write address |
| opt_wdata_i | input | 8 | Write data |
| nmi_ni | input | 1 | Non-maskable request pin, falling-edge triggered |
| pa_ni | input | 1 | Port A external request pin |
| pbc_i | input | 1 | Port B/C external request pin |
| tmr_flag_i | input | 1 | Timer underflow flag |
| adc_flag_i | input | 1 | ADC end-of-conversion flag |
| ack_i | input | 1 | CPU acknowledge of the presented vector |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | A request is being presented |
| vector_o | output | 12 | Vector address of the presented request |
| wake_wait_o | output | 1 | A pending request may end WAIT |
| wake_stop_o | output | 1 | A pending request may end STOP |

## Verification
The main stimulus is a sweep over all 32 combinations of the five sources pending at once. Each combination is drained one acknowledge at a time, which tests the priority order, the vector addresses, the wake outputs and the nesting block at every depth. Separate patterns drive port A held low against port A pulsed, and port B/C pulsed in each polarity. These show whether a request is latched or follows its level, and which edge is taken. Writes to a neighbouring address, and a cleared global enable with a timer flag held high, distinguish a register that decodes its address from one that ignores it, and a masked NMI from an unmasked one.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned NSRC   = 5;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned VEC_W  = 12;

  localparam logic [ADDR_W-1:0] OPT_ADDR = 8'hC8;
  localparam int unsigned BIT_PA_LVL  = 6;
  localparam int unsigned BIT_PBC_RISE = 5;
  localparam int unsigned BIT_GEN     = 4;

  // source index doubles as priority rank (0 highest)
  localparam int unsigned SRC_NMI = 0;
  localparam int unsigned SRC_PA  = 1;
  localparam int unsigned SRC_PBC = 2;
  localparam int unsigned SRC_TMR = 3;
  localparam int unsigned SRC_ADC = 4;

  // sources allowed to end STOP (ADC excluded)
  localparam logic [NSRC-1:0] STOP_WAKE_MASK = 5'b01111;

  typedef struct packed {
    logic pa_level;
    logic pbc_rise;
    logic gen;
  } opt_t;

  function automatic logic [VEC_W-1:0] vec_addr(input int unsigned idx);
    if (idx == SRC_NMI) return 12'hFFC;
    return 12'hFF8 - VEC_W'(2 * idx);
  endfunction
endpackage

// File: rtl/irq_opt_reg.sv
module irq_opt_reg
  import irq_prio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output opt_t              opt_o
);
  opt_t opt_q;
  logic unused_rsvd;

  assign unused_rsvd = ^{wdata_i[7], wdata_i[3:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opt_q <= '0;
    end else if (we_i && addr_i == OPT_ADDR) begin
      opt_q.pa_level <= wdata_i[BIT_PA_LVL];
      opt_q.pbc_rise <= wdata_i[BIT_PBC_RISE];
      opt_q.gen      <= wdata_i[BIT_GEN];
    end
  end

  assign opt_o = opt_q;

  assert_opt_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OPT_ADDR) |=> (opt_o.gen == $past(wdata_i[BIT_GEN])));
  assert_opt_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || addr_i != OPT_ADDR) |=> $stable(opt_o));
endmodule

// File: rtl/irq_trig.sv
module irq_trig
  import irq_prio_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  opt_t            opt_i,
  input  logic            nmi_ni,
  input  logic            pa_ni,
  input  logic            pbc_i,
  input  logic            tmr_flag_i,
  input  logic            adc_flag_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic nmi_q, pa_q, pbc_q;
  logic nmi_lat_q, pa_lat_q, pbc_lat_q;
  logic armed_q;
  logic nmi_fall, pa_fall, pbc_edge;
  logic unused_clr;

  assign unused_clr = ^clr_i[NSRC-1:SRC_TMR];

  assign nmi_fall = nmi_q & ~nmi_ni;
  assign pa_fall  = pa_q & ~pa_ni;
  assign pbc_edge = opt_i.pbc_rise ? (~pbc_q & pbc_i) : (pbc_q & ~pbc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q     <= 1'b1;
      pa_q      <= 1'b1;
      pbc_q     <= 1'b1;
      nmi_lat_q <= 1'b0;
      pa_lat_q  <= 1'b0;
      pbc_lat_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      nmi_q     <= nmi_ni;
      pa_q      <= pa_ni;
      pbc_q     <= pbc_i;
      armed_q   <= 1'b1;
      // a new edge wins over a same-cycle clear
      nmi_lat_q <= nmi_fall | (nmi_lat_q & ~clr_i[SRC_NMI]);
      pa_lat_q  <= ~opt_i.pa_level & (pa_fall | (pa_lat_q & ~clr_i[SRC_PA]));
      pbc_lat_q <= pbc_edge | (pbc_lat_q & ~clr_i[SRC_PBC]);
    end
  end

  always_comb begin
    pend_o          = '0;
    pend_o[SRC_NMI] = nmi_lat_q;
    pend_o[SRC_PA]  = opt_i.pa_level ? ~pa_ni : pa_lat_q;
    pend_o[SRC_PBC] = pbc_lat_q;
    pend_o[SRC_TMR] = tmr_flag_i;
    pend_o[SRC_ADC] = adc_flag_i;
  end

  assert_pa_fall_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !opt_i.pa_level && $fell(pa_ni)) |=> pend_o[SRC_PA]);
  assert_pbc_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && opt_i.pbc_rise && $rose(pbc_i)) |=> pend_o[SRC_PBC]);
  assert_pbc_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !opt_i.pbc_rise && $fell(pbc_i)) |=> pend_o[SRC_PBC]);
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_prio_pkg::*;
(
  input  logic [NSRC-1:0]  req_i,
  output logic [NSRC-1:0]  grant_o,
  output logic             any_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [NSRC:0] blk;

  assign blk[0] = 1'b0;
  for (genvar i = 0; i < NSRC; i++) begin : g_chain
    assign grant_o[i] = req_i[i] & ~blk[i];
    assign blk[i+1]   = blk[i] | req_i[i];
  end

  assign any_o = blk[NSRC];

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant_o[i]) vec_o = vec_o | vec_addr(i);
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              opt_we_i,
  input  logic [ADDR_W-1:0] opt_addr_i,
  input  logic [DATA_W-1:0] opt_wdata_i,
  input  logic              nmi_ni,
  input  logic              pa_ni,
  input  logic              pbc_i,
  input  logic              tmr_flag_i,
  input  logic              adc_flag_i,
  input  logic              ack_i,
  input  logic              reti_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic              wake_wait_o,
  output logic              wake_stop_o
);
  opt_t            opt;
  logic [NSRC-1:0] pend, req, grant, clr;
  logic            nest_q, mask_ok;

  irq_opt_reg u_opt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (opt_we_i),
    .addr_i  (opt_addr_i),
    .wdata_i (opt_wdata_i),
    .opt_o   (opt)
  );

  irq_trig u_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .opt_i      (opt),
    .nmi_ni     (nmi_ni),
    .pa_ni      (pa_ni),
    .pbc_i      (pbc_i),
    .tmr_flag_i (tmr_flag_i),
    .adc_flag_i (adc_flag_i),
    .clr_i      (clr),
    .pend_o     (pend)
  );

  assign mask_ok = opt.gen & ~nest_q;

  always_comb begin
    req          = pend & {NSRC{mask_ok}};
    req[SRC_NMI] = pend[SRC_NMI];
  end

  irq_arb u_arb (
    .req_i   (req),
    .grant_o (grant),
    .any_o   (irq_o),
    .vec_o   (vector_o)
  );

  assign clr = ack_i ? grant : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              nest_q <= 1'b0;
    else if (ack_i && irq_o)  nest_q <= 1'b1;
    else if (reti_i)          nest_q <= 1'b0;
  end

  assign wake_wait_o = opt.gen & (|pend);
  assign wake_stop_o = opt.gen & (|(pend & STOP_WAKE_MASK));

  assert_nest_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> nest_q);
  assert_nest_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nest_q && !pend[SRC_NMI]) |-> !irq_o);
  assert_gen_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!opt.gen && irq_o) |-> (vector_o == 12'hFFC));
  assert_nmi_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend[SRC_NMI] |-> (irq_o && vector_o == 12'hFFC));
  assert_stop_subset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_stop_o |-> wake_wait_o);
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        opt_we_i = 1'b0;
  logic [7:0]  opt_addr_i = '0;
  logic [7:0]  opt_wdata_i = '0;
  logic        nmi_ni = 1'b1, pa_ni = 1'b1, pbc_i = 1'b1;
  logic        tmr_flag_i = 1'b0, adc_flag_i = 1'b0;
  logic        ack_i = 1'b0, reti_i = 1'b0;
  logic        irq_o, wake_wait_o, wake_stop_o;
  logic [11:0] vector_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  irq_prio_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .opt_we_i(opt_we_i), .opt_addr_i(opt_addr_i), .opt_wdata_i(opt_wdata_i),
    .nmi_ni(nmi_ni), .pa_ni(pa_ni), .pbc_i(pbc_i),
    .tmr_flag_i(tmr_flag_i), .adc_flag_i(adc_flag_i),
    .ack_i(ack_i), .reti_i(reti_i),
    .irq_o(irq_o), .vector_o(vector_o),
    .wake_wait_o(wake_wait_o), .wake_stop_o(wake_stop_o)
  );

  always #5 clk_i = ~clk_i;

  function automatic logic [11:0] exp_vec(input int idx);
    return (idx == 0) ? 12'hFFC : 12'hFF8 - 12'(2 * idx);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic wr_opt(input logic [7:0] addr, input logic [7:0] data);
    tick(); opt_we_i = 1'b1; opt_addr_i = addr; opt_wdata_i = data;
    tick(); opt_we_i = 1'b0;
    #1;
  endtask

  task automatic ack_reti();
    tick(); ack_i = 1'b1;
    tick(); ack_i = 1'b0; reti_i = 1'b1;
    tick(); reti_i = 1'b0;
    #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got %0h expected %0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [4:0] rem;
    int idx;
    repeat (3) tick();
    rst_ni = 1'b1;
    #1;
    chk("R1 reset irq", irq_o, 0);
    chk("R9 reset wake", wake_wait_o, 0);

    // R5: enable clear, timer masked, NMI still taken, no wake
    tmr_flag_i = 1'b1;
    tick(); #1;
    chk("R5 timer masked", irq_o, 0);
    chk("R9 no wake gen=0", wake_wait_o, 0);
    tick(); nmi_ni = 1'b0;
    tick(); nmi_ni = 1'b1; #1;
    chk("R5 nmi irq", irq_o, 1);
    chk("R5 nmi vec", vector_o, 12'hFFC);
    chk("R9 nmi no wake", wake_wait_o | wake_stop_o, 0);
    ack_reti();
    chk("R5 nmi cleared", irq_o, 0);

    // R1: wrong address ignored, right address loads enable
    wr_opt(8'hC9, 8'h10);
    chk("R1 other addr", irq_o, 0);
    wr_opt(8'hC8, 8'h10);
    chk("R1 gen load irq", irq_o, 1);
    chk("R7 timer vec", vector_o, 12'hFF2);

    // R10: acknowledge does not clear peripheral flag
    ack_reti();
    chk("R10 flag persists", irq_o, 1);
    chk("R10 timer vec", vector_o, 12'hFF2);

    // R9: ADC only wakes WAIT
    tmr_flag_i = 1'b0; adc_flag_i = 1'b1; #1;
    chk("R9 adc wait", wake_wait_o, 1);
    chk("R9 adc stop", wake_stop_o, 0);

    // R8: nesting blocks ADC, NMI still presented
    tick(); pa_ni = 1'b0;
    tick(); pa_ni = 1'b1; #1;
    chk("R2 pa vec", vector_o, 12'hFF6);
    tick(); ack_i = 1'b1;
    tick(); ack_i = 1'b0; #1;
    chk("R8 nested block", irq_o, 0);
    nmi_ni = 1'b0;
    tick(); nmi_ni = 1'b1; #1;
    chk("R8 nmi in nest", irq_o, 1);
    chk("R8 nmi vec", vector_o, 12'hFFC);
    tick(); ack_i = 1'b1;
    tick(); ack_i = 1'b0; #1;
    chk("R8 still nested", irq_o, 0);
    reti_i = 1'b1;
    tick(); reti_i = 1'b0; #1;
    chk("R8 after reti", vector_o, 12'hFF0);
    adc_flag_i = 1'b0; #1;
    chk("R10 adc drop", irq_o, 0);

    // R3: level mode
    wr_opt(8'hC8, 8'h50);
    pa_ni = 1'b0; #1;
    chk("R3 level irq", irq_o, 1);
    chk("R3 level vec", vector_o, 12'hFF6);
    tick(); pa_ni = 1'b1; #1;
    chk("R3 not latched", irq_o, 0);

    // R4: rising mode ignores falling, takes rising
    wr_opt(8'hC8, 8'h30);
    tick(); pbc_i = 1'b0;
    tick(); #1;
    chk("R4 fall ignored", irq_o, 0);
    pbc_i = 1'b1;
    tick(); #1;
    chk("R4 rise taken", irq_o, 1);
    chk("R4 vec", vector_o, 12'hFF4);
    ack_reti();
    chk("R4 cleared", irq_o, 0);

    // sweep of all pending combinations, falling-edge modes, enable on
    wr_opt(8'hC8, 8'h10);
    for (int m = 0; m < 32; m++) begin
      tick();
      nmi_ni = !m[0]; pa_ni = !m[1]; pbc_i = !m[2];
      tmr_flag_i = m[3]; adc_flag_i = m[4];
      tick();
      nmi_ni = 1'b1; pa_ni = 1'b1; pbc_i = 1'b1;
      #1;
      rem = 5'(m);
      chk("R9 sweep wait", wake_wait_o, int'(rem != 0));
      while (rem != 0) begin
        idx = 0;
        for (int k = 4; k >= 0; k--) if (rem[k]) idx = k;
        chk("R6 sweep irq", irq_o, 1);
        chk("R7 sweep vec", vector_o, exp_vec(idx));
        chk("R9 sweep stop", wake_stop_o, int'(|rem[3:0]));
        tick(); ack_i = 1'b1;
        tick(); ack_i = 1'b0;
        rem[idx] = 1'b0;
        #1;
        chk("R8 sweep nest", irq_o, int'(rem[0]));
        reti_i = 1'b1;
        if (idx == 3) tmr_flag_i = 1'b0;
        if (idx == 4) adc_flag_i = 1'b0;
        tick(); reti_i = 1'b0;
        #1;
      end
      chk("R2 sweep drained", irq_o, 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule